// File: doc/BRIEF.md
# Leading-Stream Recovery Controller

This block repairs the architectural state of a speculative leading stream after the trailing stream, which re-executes the full program, finds that one of its own outcomes differs from a value or branch result the leading stream passed it. While the leading stream runs, the controller keeps the distinct addresses written by the leading stream's stores. When it sees a deviation signal it stalls the leading stream, flushes the inter-stream delay buffer, and reloads the leading stream's program counter. It also tells the removal predictor to back up to that precise PC.

After the PC restore, a sequenced copy engine moves every architectural register from trailing-stream state into the leading stream. It then moves the memory word at each recorded store address. Each word crosses one request/acknowledge read port on the trailing side and one request/acknowledge write port on the leading side. The store-address table has a fixed depth. If more distinct addresses arrive than it can hold, the extra ones are lost and the recovery is flagged as incomplete when it finishes. The table is emptied when a recovery ends.

Top module: `lead_recovery_ctrl`

## Requirements
- R1: Out of reset `lead_stall`, `dbuf_flush`, `pc_load`, `pred_backup`, `src_req`, `dst_req`, `rec_done` and `rec_incomplete` are all 0.
- R2: A `deviate` seen while `lead_stall` is 0 raises `lead_stall` and `dbuf_flush` in the next cycle. `dbuf_flush` lasts exactly one cycle. `lead_stall` stays 1 through the cycle in which `rec_done` is 1 and falls in the cycle after.
- R3: In the cycle after `dbuf_flush`, `pc_load` and `pred_backup` are 1 for one cycle, and `pc_value` equals the `dev_pc` sampled with the trigger.
- R4: The register copy comes first. It transfers register indices 0 to NREG-1 in ascending order with `src_mem`/`dst_mem` = 0 and the index on the address port. Each `dst_data` equals the `src_data` acknowledged for that index.
- R5: After the registers, the memory copy transfers one word for each recorded store address, in the order the addresses were first recorded, with `src_mem`/`dst_mem` = 1. It is skipped when no address is recorded.
- R6: A transfer reads first and then writes. A request holds its address and data stable until it is acknowledged, and `src_req` and `dst_req` are never 1 together.
- R7: A store (`st_valid` = 1) to an address already in the table adds no new entry, so that address is copied only once.
- R8: The table holds DEPTH (32) distinct addresses. A store to a new address when it is full is dropped and sets a sticky overflow. `rec_incomplete` is 1 together with `rec_done` exactly when an overflow occurred since the table was last emptied.
- R9: The table is emptied and the overflow cleared when `rec_done` is 1, so the next recovery copies only addresses stored after it.
- R10: `st_valid` and `deviate` are ignored while `lead_stall` is 1. Such a store is not copied later, and such a deviation starts no second recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Leading-stream store performed this cycle |
| st_addr | input | AW | Address of that store |
| deviate | input | 1 | Trailing stream detected a mismatch |
| dev_pc | input | PCW | Precise PC to resume the leading stream at |
| lead_stall | output | 1 | Holds the leading stream during recovery |
| dbuf_flush | output | 1 | Empties the inter-stream delay buffer |
| pc_load | output | 1 | Loads `pc_value` into the leading stream's PCs |
| pc_value | output | PCW | Restored PC |
| pred_backup | output | 1 | Backs the removal predictor up to `pc_value` |
| src_req | output | 1 | Read request to trailing-stream state |
| src_mem | output | 1 | 1 = memory word, 0 = register |
| src_addr | output | AW | Register index or memory address to read |
| src_ack | input | 1 | Read accepted, `src_data` valid |
| src_data | input | DW | Value read from the trailing stream |
| dst_req | output | 1 | Write request to leading-stream state |
| dst_mem | output | 1 | 1 = memory word, 0 = register |
| dst_addr | output | AW | Register index or memory address to write |
| dst_data | output | DW | Value to write |
| dst_ack | input | 1 | Write accepted |
| rec_done | output | 1 | One-cycle end-of-recovery pulse |
| rec_incomplete | output | 1 | With `rec_done`: some store addresses were lost |

## Verification
The bench targets stores that repeat an address. A design without de-duplication would copy the same word several times. It also fills the table exactly to its depth and then past it: an off-by-one design would either flag a full table as incomplete or keep a 33rd entry. A recovery with no recorded stores must go straight from the last register to the end. A design that enters the memory phase anyway would issue a copy from a stale entry. Finally, stores and deviations injected while a recovery runs must leave no trace. A design that kept them would copy an extra word in the following recovery or restart the sequence.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FLUSH = 3'd1,
    ST_PC    = 3'd2,
    ST_REGS  = 3'd3,
    ST_MEM   = 3'd4,
    ST_DONE  = 3'd5
  } rcv_state_e;

  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } xfer_phase_e;
endpackage

// File: rtl/store_addr_table.sv
module store_addr_table #(
  parameter int AW    = 32,
  parameter int DEPTH = 32,
  parameter int XW    = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          clr,
  input  logic [XW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [AW-1:0]    ent [DEPTH];
  logic [DEPTH-1:0] match;
  logic             hit, full, ins, lose;
  logic [CW-1:0]    count_nxt;
  logic             ovf_nxt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign match[i] = (CW'(i) < count) && (ent[i] == wr_addr);
    always_ff @(posedge clk) begin
      if (ins && (count == CW'(i))) ent[i] <= wr_addr;
    end
  end

  assign hit  = |match;
  assign full = (count == CW'(DEPTH));
  assign ins  = wr_en && !hit && !full;
  assign lose = wr_en && !hit && full;

  always_comb begin
    rd_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == XW'(i)) rd_addr = ent[i];
    end
  end

  always_comb begin
    count_nxt = count;
    ovf_nxt   = ovf;
    if (clr) begin
      count_nxt = '0;
      ovf_nxt   = 1'b0;
    end else begin
      if (ins)  count_nxt = count + CW'(1);
      if (lose) ovf_nxt   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= count_nxt;
      ovf   <= ovf_nxt;
    end
  end
endmodule

// File: rtl/recov_seq.sv
module recov_seq
  import rcv_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  parameter int NREG  = 32,
  parameter int DEPTH = 32,
  parameter int XW    = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           deviate,
  input  logic [PCW-1:0] dev_pc,
  input  logic [CW-1:0]  tbl_count,
  input  logic [AW-1:0]  tbl_addr,
  output logic [XW-1:0]  tbl_idx,
  output logic           busy,
  output logic           flush,
  output logic           pc_load,
  output logic [PCW-1:0] pc_value,
  output logic           src_req,
  output logic           src_mem,
  output logic [AW-1:0]  src_addr,
  input  logic           src_ack,
  input  logic [DW-1:0]  src_data,
  output logic           dst_req,
  output logic           dst_mem,
  output logic [AW-1:0]  dst_addr,
  output logic [DW-1:0]  dst_data,
  input  logic           dst_ack,
  output logic           done
);
  rcv_state_e  state, state_nxt;
  xfer_phase_e phase, phase_nxt;
  logic [XW-1:0]  idx, idx_nxt;
  logic [DW-1:0]  buf_q;
  logic [PCW-1:0] pc_q;
  logic           pc_en, buf_en, copying, last_reg, last_mem;
  logic [AW-1:0]  cur_addr;

  assign copying  = (state == ST_REGS) || (state == ST_MEM);
  assign last_reg = (idx == XW'(NREG - 1));
  assign last_mem = (XW'(idx + XW'(1)) == XW'(tbl_count));
  assign pc_en    = (state == ST_IDLE) && deviate;
  assign buf_en   = copying && (phase == PH_READ) && src_ack;
  assign cur_addr = (state == ST_MEM) ? tbl_addr : AW'(idx);

  always_comb begin
    state_nxt = state;
    phase_nxt = phase;
    idx_nxt   = idx;
    unique case (state)
      ST_IDLE:  if (deviate) state_nxt = ST_FLUSH;
      ST_FLUSH: state_nxt = ST_PC;
      ST_PC: begin
        state_nxt = ST_REGS;
        phase_nxt = PH_READ;
        idx_nxt   = '0;
      end
      ST_REGS, ST_MEM: begin
        if (phase == PH_READ) begin
          if (src_ack) phase_nxt = PH_WRITE;
        end else if (dst_ack) begin
          phase_nxt = PH_READ;
          if (state == ST_REGS && last_reg) begin
            idx_nxt   = '0;
            state_nxt = (tbl_count == '0) ? ST_DONE : ST_MEM;
          end else if (state == ST_MEM && last_mem) begin
            state_nxt = ST_DONE;
          end else begin
            idx_nxt = idx + XW'(1);
          end
        end
      end
      ST_DONE:  state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_READ;
      idx   <= '0;
    end else begin
      state <= state_nxt;
      phase <= phase_nxt;
      idx   <= idx_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (pc_en)  pc_q  <= dev_pc;
    if (buf_en) buf_q <= src_data;
  end

  assign tbl_idx  = idx;
  assign busy     = (state != ST_IDLE);
  assign flush    = (state == ST_FLUSH);
  assign pc_load  = (state == ST_PC);
  assign pc_value = pc_q;
  assign src_req  = copying && (phase == PH_READ);
  assign dst_req  = copying && (phase == PH_WRITE);
  assign src_mem  = (state == ST_MEM);
  assign dst_mem  = (state == ST_MEM);
  assign src_addr = cur_addr;
  assign dst_addr = cur_addr;
  assign dst_data = buf_q;
  assign done     = (state == ST_DONE);
endmodule

// File: rtl/lead_recovery_ctrl.sv
module lead_recovery_ctrl #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  parameter int NREG  = 32,
  parameter int DEPTH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_valid,
  input  logic [AW-1:0]  st_addr,
  input  logic           deviate,
  input  logic [PCW-1:0] dev_pc,
  output logic           lead_stall,
  output logic           dbuf_flush,
  output logic           pc_load,
  output logic [PCW-1:0] pc_value,
  output logic           pred_backup,
  output logic           src_req,
  output logic           src_mem,
  output logic [AW-1:0]  src_addr,
  input  logic           src_ack,
  input  logic [DW-1:0]  src_data,
  output logic           dst_req,
  output logic           dst_mem,
  output logic [AW-1:0]  dst_addr,
  output logic [DW-1:0]  dst_data,
  input  logic           dst_ack,
  output logic           rec_done,
  output logic           rec_incomplete
);
  localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int TIW = $clog2(DEPTH + 1);
  localparam int XW  = ((RIW > TIW) ? RIW : TIW) + 1;
  localparam int CW  = $clog2(DEPTH + 1);

  logic [CW-1:0] tbl_count;
  logic [AW-1:0] tbl_addr;
  logic [XW-1:0] tbl_idx;
  logic          tbl_ovf, busy, done;

  store_addr_table #(.AW(AW), .DEPTH(DEPTH), .XW(XW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_valid && !busy),
    .wr_addr (st_addr),
    .clr     (done),
    .rd_idx  (tbl_idx),
    .rd_addr (tbl_addr),
    .count   (tbl_count),
    .ovf     (tbl_ovf)
  );

  recov_seq #(.AW(AW), .DW(DW), .PCW(PCW), .NREG(NREG), .DEPTH(DEPTH), .XW(XW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .deviate   (deviate),
    .dev_pc    (dev_pc),
    .tbl_count (tbl_count),
    .tbl_addr  (tbl_addr),
    .tbl_idx   (tbl_idx),
    .busy      (busy),
    .flush     (dbuf_flush),
    .pc_load   (pc_load),
    .pc_value  (pc_value),
    .src_req   (src_req),
    .src_mem   (src_mem),
    .src_addr  (src_addr),
    .src_ack   (src_ack),
    .src_data  (src_data),
    .dst_req   (dst_req),
    .dst_mem   (dst_mem),
    .dst_addr  (dst_addr),
    .dst_data  (dst_data),
    .dst_ack   (dst_ack),
    .done      (done)
  );

  assign lead_stall     = busy;
  assign pred_backup    = pc_load;
  assign rec_done       = done;
  assign rec_incomplete = done && tbl_ovf;
endmodule

// File: rtl/rcv_checker.sv
module rcv_checker #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           deviate,
  input logic [PCW-1:0] dev_pc,
  input logic           lead_stall,
  input logic           dbuf_flush,
  input logic           pc_load,
  input logic [PCW-1:0] pc_value,
  input logic           pred_backup,
  input logic           src_req,
  input logic [AW-1:0]  src_addr,
  input logic           src_ack,
  input logic           dst_req,
  input logic [AW-1:0]  dst_addr,
  input logic [DW-1:0]  dst_data,
  input logic           dst_ack,
  input logic           rec_done,
  input logic           rec_incomplete
);
  a_r2_trigger_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (deviate && !lead_stall) |=> (lead_stall && dbuf_flush));
  a_r2_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_flush |=> !dbuf_flush);
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !lead_stall);
  a_r3_pc_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_flush |=> (pc_load && pred_backup));
  a_r3_pc_value: assert property (@(posedge clk) disable iff (!rst_n)
    (deviate && !lead_stall) |=> ##1 (pc_value == $past(dev_pc, 2)));
  a_r6_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_ack) |=> (src_req && $stable(src_addr)));
  a_r6_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && !dst_ack) |=> (dst_req && $stable(dst_addr) && $stable(dst_data)));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_req && dst_req));
  a_r8_incomplete_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rec_incomplete |-> rec_done);
  a_r10_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stall && !dbuf_flush) |=> !dbuf_flush);
endmodule

bind lead_recovery_ctrl rcv_checker #(.AW(AW), .DW(DW), .PCW(PCW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .deviate        (deviate),
  .dev_pc         (dev_pc),
  .lead_stall     (lead_stall),
  .dbuf_flush     (dbuf_flush),
  .pc_load        (pc_load),
  .pc_value       (pc_value),
  .pred_backup    (pred_backup),
  .src_req        (src_req),
  .src_addr       (src_addr),
  .src_ack        (src_ack),
  .dst_req        (dst_req),
  .dst_addr       (dst_addr),
  .dst_data       (dst_data),
  .dst_ack        (dst_ack),
  .rec_done       (rec_done),
  .rec_incomplete (rec_incomplete)
);

// File: tb/test_lead_recovery_ctrl.sv
`timescale 1ns/1ps
module test_lead_recovery_ctrl;
  localparam int AW = 32, DW = 32, PCW = 32, NREG = 32, DEPTH = 32;

  typedef struct packed {
    logic [31:0] nst;
    logic [31:0] base;
    logic [31:0] stride;
    logic [31:0] ecnt;
    logic        einc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{32'd3,  32'h0000_0100, 32'd4, 32'd3,  1'b0},
    '{32'd5,  32'h0000_0200, 32'd0, 32'd1,  1'b0},
    '{32'd0,  32'h0000_0000, 32'd0, 32'd0,  1'b0},
    '{32'd32, 32'h0000_1000, 32'd8, 32'd32, 1'b0},
    '{32'd40, 32'h0000_2000, 32'd4, 32'd32, 1'b1},
    '{32'd1,  32'h0000_3000, 32'd4, 32'd1,  1'b0}
  };

  logic clk, rst_n;
  logic st_valid, deviate, src_ack, dst_ack;
  logic [AW-1:0]  st_addr;
  logic [PCW-1:0] dev_pc;
  logic [DW-1:0]  src_data;
  logic lead_stall, dbuf_flush, pc_load, pred_backup;
  logic [PCW-1:0] pc_value;
  logic src_req, src_mem, dst_req, dst_mem, rec_done, rec_incomplete;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] dst_data;

  int total, bad, cyc;
  int reg_wr, reg_err, mem_wr;
  logic [AW-1:0] mem_log [256];

  lead_recovery_ctrl #(.AW(AW), .DW(DW), .PCW(PCW), .NREG(NREG), .DEPTH(DEPTH)) i_lead_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .deviate(deviate), .dev_pc(dev_pc), .lead_stall(lead_stall),
    .dbuf_flush(dbuf_flush), .pc_load(pc_load), .pc_value(pc_value),
    .pred_backup(pred_backup), .src_req(src_req), .src_mem(src_mem),
    .src_addr(src_addr), .src_ack(src_ack), .src_data(src_data),
    .dst_req(dst_req), .dst_mem(dst_mem), .dst_addr(dst_addr),
    .dst_data(dst_data), .dst_ack(dst_ack), .rec_done(rec_done),
    .rec_incomplete(rec_incomplete)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] src_val(logic m, logic [AW-1:0] a);
    return m ? (a ^ 32'h5A5A_0000) : (32'hA000_0000 + a);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // responder for both handshake ports; also logs writes
  initial begin
    src_ack = 1'b0; dst_ack = 1'b0; src_data = '0;
    reg_wr = 0; reg_err = 0; mem_wr = 0;
    forever begin
      @(negedge clk);
      if (src_req && !src_ack) begin
        src_ack  = 1'b1;
        src_data = src_val(src_mem, src_addr);
      end else src_ack = 1'b0;
      if (dst_req && !dst_ack) begin
        dst_ack = 1'b1;
        if (!dst_mem) begin
          if (dst_addr != AW'(reg_wr % NREG) || dst_data != src_val(1'b0, dst_addr)) reg_err++;
          reg_wr++;
        end else begin
          if (dst_data != src_val(1'b1, dst_addr)) reg_err++;
          if (mem_wr < 256) mem_log[mem_wr] = dst_addr;
          mem_wr++;
        end
      end else dst_ack = 1'b0;
    end
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
      end
    end
  end

  task automatic do_stores(int n, logic [AW-1:0] base, logic [AW-1:0] stride);
    for (int k = 0; k < n; k++) begin
      st_valid = 1'b1;
      st_addr  = base + AW'(k) * stride;
      @(negedge clk);
    end
    st_valid = 1'b0;
  endtask

  // runs one recovery; optional injection of a store and a deviation mid-way
  task automatic recover(logic [PCW-1:0] pc, int ecnt, logic einc,
                         logic [AW-1:0] base, logic [AW-1:0] stride, bit inject);
    int r0, m0, e0, w;
    r0 = reg_wr; m0 = mem_wr; e0 = reg_err;
    deviate = 1'b1; dev_pc = pc;
    @(negedge clk);
    deviate = 1'b0; dev_pc = ~pc;
    check("R2 stall after trigger", lead_stall, 1);
    check("R2 flush after trigger", dbuf_flush, 1);
    @(negedge clk);
    check("R2 flush one cycle", dbuf_flush, 0);
    check("R3 pc_load", pc_load, 1);
    check("R3 pred_backup", pred_backup, 1);
    check("R3 pc_value", pc_value, pc);
    if (inject) begin
      @(negedge clk);
      st_valid = 1'b1; st_addr = 32'h0000_7777; deviate = 1'b1; dev_pc = 32'h0BAD;
      @(negedge clk);
      st_valid = 1'b0; deviate = 1'b0;
    end
    w = 0;
    while (!rec_done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check("R2 stall during done", lead_stall, 1);
    check("R8 incomplete", rec_incomplete, einc);
    check("R4 register count", reg_wr - r0, NREG);
    check("R4 register order and data", reg_err - e0, 0);
    check("R5 memory count", mem_wr - m0, ecnt);
    for (int k = 0; k < ecnt; k++)
      if (m0 + k < 256) check("R5 memory order", mem_log[m0 + k], base + AW'(k) * stride);
    @(negedge clk);
    check("R2 stall released", lead_stall, 0);
  endtask

  initial begin
    total = 0; bad = 0;
    st_valid = 1'b0; st_addr = '0; deviate = 1'b0; dev_pc = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 stall reset", lead_stall, 0);
    check("R1 flush reset", dbuf_flush, 0);
    check("R1 pc_load reset", {pc_load, pred_backup}, 0);
    check("R1 req reset", {src_req, dst_req}, 0);
    check("R1 done reset", {rec_done, rec_incomplete}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R5 ordering, R7 duplicates, R8 overflow, R9 clearing between runs
    for (int v = 0; v < NV; v++) begin
      do_stores(int'(VEC[v].nst), VEC[v].base, VEC[v].stride);
      recover(32'h4000 + 32'(v) * 32'h10, int'(VEC[v].ecnt), VEC[v].einc,
              VEC[v].base, VEC[v].stride, 1'b0);
      @(negedge clk);
    end

    // R10: store and deviation during recovery are dropped
    do_stores(2, 32'h0000_5000, 32'd4);
    recover(32'h8000, 2, 1'b0, 32'h0000_5000, 32'd4, 1'b1);
    repeat (3) @(negedge clk);
    check("R10 no second recovery", {lead_stall, dbuf_flush}, 0);
    recover(32'h9000, 0, 1'b0, '0, '0, 1'b0);

    // R9: overflow flag cleared by completion
    do_stores(33, 32'h0000_6000, 32'd4);
    recover(32'hA000, 32, 1'b1, 32'h0000_6000, 32'd4, 1'b0);
    do_stores(1, 32'h0000_6100, 32'd4);
    recover(32'hB000, 1, 1'b0, 32'h0000_6100, 32'd4, 1'b0);

    finish_run();
  end
endmodule